// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block holds the pending state for the interrupts private to one processor: a bank of software-generated interrupts (ids 0 to NUM_SW-1) and a bank of per-processor peripheral interrupts (ids NUM_SW upward). Peripheral input lines are sampled into a stored level vector every clock. A line configured as edge-triggered latches its pending bit on a 0-to-1 change. A line configured as level-sensitive contributes its stored level directly to the effective pending view.

Software-generated requests arrive as a single-cycle strobe. Each strobe carries a target id, a requested group and a secure or non-secure origin. The block works out the configured group of the target from its group and group-modifier bits. It lets a secure group 1 request fall back to group 0 when the target is a group 0 interrupt. It discards requests whose group does not match. When security is enabled, non-secure requests must also pass a graded 2-bit access level held per id. Set and clear pulses from a register file act on the same latch in the same cycle as these events. A set always wins over a clear.

Top module: `ppt_pend_tracker`

## Requirements
- R1: A peripheral line held at a level equal to its stored level changes no state; a line held high after its latch is cleared does not latch again.
- R2: A 0-to-1 change on an edge-configured line (edge_cfg_i bit 1) sets latch bit NUM_SW+k one cycle later. A 1-to-0 change never clears the latch. The latch only drops through a clear pulse.
- R3: For a level-configured line (edge_cfg_i bit 0), eff_pend_o bit NUM_SW+k equals the latch bit ORed with the stored line level, and the line does not set the latch.
- R4: The configured group of software id i is non-secure group 1 when grp_i[i]=1. When grp_i[i]=0 it is group 0 if grpmod_i[i]=0 and secure group 1 if grpmod_i[i]=1. With sec_dis_i=1 the modifier is ignored (grp_i[i]=0 means group 0).
- R5: A request with sgi_grp_i=1 (secure group 1) targeting a group 0 interrupt is treated as a group 0 request. Request encodings: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 matches nothing.
- R6: A request whose group, after the R5 adjustment, differs from the configured group leaves all state unchanged.
- R7: When sgi_ns_i=1 and sec_dis_i=0, the access field nsacc_i[2*id+1:2*id] must be at least 1 for a group 0 target and at least 2 for a secure group 1 target; otherwise the request is dropped. Non-secure group 1 targets need no field.
- R8: An accepted request sets latch bit id one cycle after the strobe and touches no other bit.
- R9: set_i and clr_i act on the latch one cycle later. A set, edge or accepted request on a bit wins over a clear on the same bit in the same cycle.
- R10: After reset the latch, the stored levels and both pending outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_PERIPH | Peripheral interrupt lines, synchronous to clk |
| edge_cfg_i | input | NUM_PERIPH | 1 = edge-triggered, 0 = level-sensitive, per peripheral line |
| grp_i | input | NUM_SW | Group bit per software id |
| grpmod_i | input | NUM_SW | Group-modifier bit per software id |
| nsacc_i | input | 2*NUM_SW | 2-bit non-secure access level per software id |
| sec_dis_i | input | 1 | 1 = security disabled |
| sgi_vld_i | input | 1 | Software request strobe |
| sgi_id_i | input | ID_W | Target software id |
| sgi_grp_i | input | 2 | Requested group |
| sgi_ns_i | input | 1 | 1 = request from non-secure origin |
| set_i | input | NUM_SW+NUM_PERIPH | Register-file set pulses |
| clr_i | input | NUM_SW+NUM_PERIPH | Register-file clear pulses |
| pend_o | output | NUM_SW+NUM_PERIPH | Pending latch |
| eff_pend_o | output | NUM_SW+NUM_PERIPH | Effective pending (latch plus level lines) |

## Verification
Software requests are swept over every id, both group bits, both modifier bits, all four requested-group codes, both origins, all four access levels and both security settings. The other ids carry different group and access settings, so a wrong bit or field index in the acceptance logic shows as a wrong result. Every peripheral line is exercised in edge mode with a rising edge, a held high level after a clear and a falling edge. This separates edge detection from level following and from clear handling. Level mode is then checked on the effective view against the latch. Simultaneous set and clear on every bit pins down the priority rule.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

   typedef enum logic [1:0] {
      GRP_G0     = 2'd0,
      GRP_G1_SEC = 2'd1,
      GRP_G1_NS  = 2'd2,
      GRP_NONE   = 2'd3
   } ppt_grp_e;

   // Configured group from the group and modifier bits; modifier is
   // meaningless when security is off.
   function automatic ppt_grp_e cfg_group(input logic g, input logic m,
                                          input logic sec_off);
      if (g)
         return GRP_G1_NS;
      else if (m && !sec_off)
         return GRP_G1_SEC;
      else
         return GRP_G0;
   endfunction

endpackage

// File: rtl/ppt_line_sampler.sv
module ppt_line_sampler #(
   parameter int NUM_PERIPH = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PERIPH-1:0] line_i,
   input  logic [NUM_PERIPH-1:0] edge_cfg_i,
   output logic [NUM_PERIPH-1:0] lvl_o,
   output logic [NUM_PERIPH-1:0] rise_o
);

   logic [NUM_PERIPH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= '0;
      else
         lvl_q <= line_i;
   end

   // only a change from stored 0 to input 1 on an edge line counts
   assign rise_o = line_i & ~lvl_q & edge_cfg_i;
   assign lvl_o  = lvl_q;

endmodule

// File: rtl/ppt_sgi_gate.sv
module ppt_sgi_gate
   import ppt_pkg::*;
#(
   parameter int NUM_SW = 16,
   parameter int ID_W   = 4
) (
   input  logic              req_vld_i,
   input  logic [ID_W-1:0]   req_id_i,
   input  ppt_grp_e          req_grp_i,
   input  logic              req_ns_i,
   input  logic              sec_dis_i,
   input  logic [NUM_SW-1:0] grp_i,
   input  logic [NUM_SW-1:0] grpmod_i,
   input  logic [2*NUM_SW-1:0] nsacc_i,
   output logic [NUM_SW-1:0] hit_o
);

   generate
      for (genvar i = 0; i < NUM_SW; i++) begin : g_id
         ppt_grp_e   cfg_g;
         ppt_grp_e   adj_g;
         logic [1:0] lvl;
         logic       sel;
         logic       acc_ok;

         assign sel   = req_vld_i && (req_id_i == ID_W'(i));
         assign cfg_g = cfg_group(grp_i[i], grpmod_i[i], sec_dis_i);
         assign adj_g = (req_grp_i == GRP_G1_SEC && cfg_g == GRP_G0) ? GRP_G0
                                                                     : req_grp_i;
         assign lvl   = nsacc_i[2*i +: 2];

         always_comb begin
            acc_ok = 1'b1;
            if (req_ns_i && !sec_dis_i) begin
               unique case (cfg_g)
                  GRP_G0:     acc_ok = (lvl >= 2'd1);
                  GRP_G1_SEC: acc_ok = (lvl >= 2'd2);
                  default:    acc_ok = 1'b1;
               endcase
            end
         end

         assign hit_o[i] = sel && (adj_g == cfg_g) && acc_ok;
      end
   endgenerate

endmodule

// File: rtl/ppt_pend_array.sv
module ppt_pend_array #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (set_i[b])
               q <= 1'b1;
            else if (clr_i[b])
               q <= 1'b0;
         end
         assign pend_o[b] = q;
      end
   endgenerate

endmodule

// File: rtl/ppt_pend_tracker.sv
module ppt_pend_tracker
   import ppt_pkg::*;
#(
   parameter int NUM_SW     = 16,
   parameter int NUM_PERIPH = 16,
   parameter int ID_W       = (NUM_SW > 1) ? $clog2(NUM_SW) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PERIPH-1:0]        line_i,
   input  logic [NUM_PERIPH-1:0]        edge_cfg_i,
   input  logic [NUM_SW-1:0]            grp_i,
   input  logic [NUM_SW-1:0]            grpmod_i,
   input  logic [2*NUM_SW-1:0]          nsacc_i,
   input  logic                         sec_dis_i,
   input  logic                         sgi_vld_i,
   input  logic [ID_W-1:0]              sgi_id_i,
   input  logic [1:0]                   sgi_grp_i,
   input  logic                         sgi_ns_i,
   input  logic [NUM_SW+NUM_PERIPH-1:0] set_i,
   input  logic [NUM_SW+NUM_PERIPH-1:0] clr_i,
   output logic [NUM_SW+NUM_PERIPH-1:0] pend_o,
   output logic [NUM_SW+NUM_PERIPH-1:0] eff_pend_o
);

   localparam int NUM_IRQ = NUM_SW + NUM_PERIPH;

   initial begin
      assert (NUM_SW >= 2 && NUM_PERIPH >= 1)
         else $error("ppt_pend_tracker: bank sizes out of range");
      assert ((1 << ID_W) >= NUM_SW)
         else $error("ppt_pend_tracker: ID_W too narrow for NUM_SW");
   end

   logic [NUM_PERIPH-1:0] lvl_q;
   logic [NUM_PERIPH-1:0] rise_hit;
   logic [NUM_SW-1:0]     sgi_hit;
   logic [NUM_IRQ-1:0]    set_all;
   logic [NUM_IRQ-1:0]    lvl_view;

   ppt_line_sampler #(.NUM_PERIPH(NUM_PERIPH)) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .edge_cfg_i (edge_cfg_i),
      .lvl_o      (lvl_q),
      .rise_o     (rise_hit)
   );

   ppt_sgi_gate #(.NUM_SW(NUM_SW), .ID_W(ID_W)) u_gate (
      .req_vld_i  (sgi_vld_i),
      .req_id_i   (sgi_id_i),
      .req_grp_i  (ppt_grp_e'(sgi_grp_i)),
      .req_ns_i   (sgi_ns_i),
      .sec_dis_i  (sec_dis_i),
      .grp_i      (grp_i),
      .grpmod_i   (grpmod_i),
      .nsacc_i    (nsacc_i),
      .hit_o      (sgi_hit)
   );

   // every set source beats a clear on the same bit
   assign set_all = set_i | {rise_hit, sgi_hit};

   ppt_pend_array #(.N(NUM_IRQ)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_all),
      .clr_i  (clr_i),
      .pend_o (pend_o)
   );

   assign lvl_view   = {lvl_q & ~edge_cfg_i, {NUM_SW{1'b0}}};
   assign eff_pend_o = pend_o | lvl_view;

endmodule

// File: rtl/ppt_pend_tracker_chk.sv
module ppt_pend_tracker_chk #(
   parameter int NUM_SW     = 16,
   parameter int NUM_PERIPH = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         sgi_vld_i,
   input logic [NUM_SW+NUM_PERIPH-1:0] set_i,
   input logic [NUM_SW+NUM_PERIPH-1:0] clr_i,
   input logic [NUM_SW+NUM_PERIPH-1:0] pend_o,
   input logic [NUM_PERIPH-1:0]        rise_hit,
   input logic [NUM_SW-1:0]            sgi_hit
);

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

   // R2
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_hit != '0) |=>
         ((pend_o[NUM_SW+NUM_PERIPH-1:NUM_SW] & $past(rise_hit)) == $past(rise_hit)));

   // R2
   no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

   // R8
   sgi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sgi_hit));

   // R6
   sgi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sgi_vld_i && sgi_hit == '0 && set_i == '0 && clr_i == '0 && rise_hit == '0)
         |=> $stable(pend_o));

endmodule

bind ppt_pend_tracker ppt_pend_tracker_chk #(
   .NUM_SW     (NUM_SW),
   .NUM_PERIPH (NUM_PERIPH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sgi_vld_i (sgi_vld_i),
   .set_i     (set_i),
   .clr_i     (clr_i),
   .pend_o    (pend_o),
   .rise_hit  (rise_hit),
   .sgi_hit   (sgi_hit)
);

// File: tb/ppt_pend_tracker_tb.sv
`timescale 1ns/1ps
module ppt_pend_tracker_tb;

   localparam int NS = 16;
   localparam int NP = 16;
   localparam int NI = NS + NP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] line_i = '0;
   logic [NP-1:0] edge_cfg_i = '1;
   logic [NS-1:0] grp_i = '0;
   logic [NS-1:0] grpmod_i = '0;
   logic [2*NS-1:0] nsacc_i = '0;
   logic          sec_dis_i = 1'b0;
   logic          sgi_vld_i = 1'b0;
   logic [3:0]    sgi_id_i = '0;
   logic [1:0]    sgi_grp_i = '0;
   logic          sgi_ns_i = 1'b0;
   logic [NI-1:0] set_i = '0;
   logic [NI-1:0] clr_i = '0;
   logic [NI-1:0] pend_o;
   logic [NI-1:0] eff_pend_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ppt_pend_tracker #(.NUM_SW(NS), .NUM_PERIPH(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .edge_cfg_i(edge_cfg_i),
      .grp_i(grp_i), .grpmod_i(grpmod_i), .nsacc_i(nsacc_i),
      .sec_dis_i(sec_dis_i), .sgi_vld_i(sgi_vld_i), .sgi_id_i(sgi_id_i),
      .sgi_grp_i(sgi_grp_i), .sgi_ns_i(sgi_ns_i), .set_i(set_i),
      .clr_i(clr_i), .pend_o(pend_o), .eff_pend_o(eff_pend_o)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [NI-1:0] act,
                      input logic [NI-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      clr_i = '1;
      tick();
      clr_i = '0;
   endtask

   // 0 = group 0, 1 = secure group 1, 2 = non-secure group 1
   function automatic int cfg_of(int gb, int gm, int sd);
      if (gb != 0) return 2;
      if (gm != 0 && sd == 0) return 1;
      return 0;
   endfunction

   function automatic bit accept(int gb, int gm, int rq, int ns, int f,
                                 int sd, output string tag);
      int c = cfg_of(gb, gm, sd);
      int r = rq;
      tag = "R8";
      if (r == 1 && c == 0) begin r = 0; tag = "R5"; end
      if (r != c) begin tag = "R6"; return 0; end
      if (ns != 0 && sd == 0) begin
         if ((c == 0 && f < 1) || (c == 1 && f < 2)) begin
            tag = "R7"; return 0;
         end
      end
      return 1;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      // R10: reset state
      chk("R10 pend", pend_o, '0);
      chk("R10 eff", eff_pend_o, '0);
      rst_n = 1'b1;
      tick();

      // peripheral lines, edge mode
      for (int k = 0; k < NP; k++) begin
         logic [NI-1:0] b;
         b = NI'(1) << (NS + k);
         edge_cfg_i = '1;
         line_i[k] = 1'b1;
         tick();
         chk("R2 rise latch", pend_o, b);
         chk("R2 rise eff", eff_pend_o, b);
         clr_i = b;
         tick();
         clr_i = '0;
         tick();
         chk("R1 held high no relatch", pend_o, '0);
         line_i[k] = 1'b0;
         tick();
         line_i[k] = 1'b1;
         tick();
         chk("R2 second rise", pend_o, b);
         line_i[k] = 1'b0;
         tick();
         chk("R2 fall keeps latch", pend_o, b);
         clear_all();
         // level mode
         edge_cfg_i = '0;
         line_i[k] = 1'b1;
         tick();
         chk("R3 level no latch", pend_o, '0);
         chk("R3 level eff", eff_pend_o, b);
         line_i[k] = 1'b0;
         tick();
         chk("R3 level low eff", eff_pend_o, '0);
      end
      edge_cfg_i = '1;

      // R9: set beats clear
      for (int q = 0; q < NI; q++) begin
         logic [NI-1:0] b;
         b = NI'(1) << q;
         set_i = b; clr_i = b;
         tick();
         set_i = '0; clr_i = '0;
         chk("R9 set wins", pend_o, b);
         clr_i = b;
         tick();
         clr_i = '0;
         chk("R9 clear", pend_o, '0);
      end

      // R4..R8: software request sweep
      for (int id = 0; id < NS; id++)
       for (int gb = 0; gb < 2; gb++)
        for (int gm = 0; gm < 2; gm++)
         for (int rq = 0; rq < 4; rq++)
          for (int ns = 0; ns < 2; ns++)
           for (int f = 0; f < 4; f++)
            for (int sd = 0; sd < 2; sd++) begin
               string tag;
               bit    ok;
               logic [NS-1:0] one;
               one = NS'(1) << id;
               grp_i    = (gb != 0) ? one : ~one;
               grpmod_i = (gm != 0) ? one : ~one;
               for (int j = 0; j < NS; j++)
                  nsacc_i[2*j +: 2] = (j == id) ? 2'(f) : 2'(3 - f);
               sec_dis_i = sd[0];
               clr_i = '1;
               tick();
               clr_i = '0;
               sgi_vld_i = 1'b1;
               sgi_id_i  = 4'(id);
               sgi_grp_i = 2'(rq);
               sgi_ns_i  = ns[0];
               tick();
               sgi_vld_i = 1'b0;
               ok = accept(gb, gm, rq, ns, f, sd, tag);
               // R4 group derivation feeds every expected value here
               chk({tag, " R4 sgi"}, pend_o, ok ? (NI'(1) << id) : '0);
            end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule